// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with LRU Replacement

This block sits between a processor and a word-wide memory. It is a small cache with two ways in every set. Each way holds one word plus its tag and a valid flag. A request carries a byte address. The block reads the two entries of the addressed set and compares both tags with the request tag at the same time. A read that matches is served from the cache without a memory access. A read that misses fetches the word from memory, returns it, and places it in one of the two ways.

Writes always go through to memory, so no entry is ever dirty and an eviction needs no write-back. A write that hits also updates the cached copy. A write that misses leaves the cache unchanged. Each set has one recency bit. It names the way that will be replaced next, and it flips on every hit and every fill so that it points away from the way just used.

The processor side uses a one-cycle request pulse. The block accepts a request only while idle and answers with a one-cycle done pulse that carries the read word and a hit flag. The memory side holds its request until memory acknowledges it.

Top module: `cache_2way_lru`

## Requirements
- R1: After reset every way of every set is invalid, `cpu_done_o` and `mem_req_o` are low, and the first read of any address is a miss.
- R2: The 8-bit byte address is split as tag = bits 7:4, set = bits 3:2 and byte-in-word = bits 1:0. The byte bits do not affect lookup. `mem_addr_o` carries address bits 7:2 as a word address.
- R3: A read miss raises `mem_req_o` with `mem_we_o` low. When `mem_ack_i` arrives, the block returns `mem_rdata_i` with `cpu_hit_o` low and stores that word in the set.
- R4: A read hit returns the stored word with `cpu_hit_o` high and makes no memory access.
- R5: Two addresses with the same set and different tags (0x30 and 0xB0) can both be resident, so each one hits after both have been read.
- R6: On a miss, an invalid way in the set is filled before any valid way is evicted.
- R7: Each set keeps one recency bit. It is updated on every hit and every fill, and a miss into a full set evicts the way that was not used most recently.
- R8: Every write issues one memory write of `cpu_wdata_i` to the word address. `cpu_done_o` follows only after `mem_ack_i`.
- R9: A write hit updates the matching way and makes it most recently used. A write miss allocates nothing, so a following read of that address misses and returns the memory copy.
- R10: A lookup never finds the request tag valid in both ways of a set.
- R11: `cpu_done_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Request pulse, accepted while idle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 8 | Byte address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_hit_o | output | 1 | Request hit in the cache, valid with done |
| cpu_rdata_o | output | 32 | Read word, valid with done on reads |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 6 | Memory word address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_rdata_i | input | 32 | Memory read word, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |

## Verification
The bench reads two tags that share set 0. A design that compares only one way, or always fills the same way, would then miss again on the first tag. A recency sequence in one set (fill A and B, hit A, miss C) shows whether B is the victim and whether A survives. A design that skips the update on hits would evict A instead. A write hit followed by a miss into the same set checks that writes also refresh recency. A write miss followed by a read checks that the design does not allocate on a write miss, and a second read with different byte bits checks that those bits are ignored.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_WRITE,
    ST_RESP
  } ctrl_state_e;
endpackage

// File: rtl/cache_way.sv
module cache_way #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[set_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[set_i]  <= tag_i;
      data_q[set_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[set_i];
  assign hit_o   = valid_q[set_i] && (tag_q[set_i] == tag_i);
  assign data_o  = data_q[set_i];

  // a written entry is resident and matches its own tag afterwards
  assert_fill_resident_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (valid_q[$past(set_i)] && tag_q[$past(set_i)] == $past(tag_i)));
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int unsigned SET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic             touch_way_i,
  output logic             victim_o
);
  localparam int unsigned SETS = 1 << SET_W;

  // bit per set names the least recently used way
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (touch_i) lru_q[set_i] <= ~touch_way_i;
  end

  assign victim_o = lru_q[set_i];

  assert_victim_not_mru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (lru_q[$past(set_i)] != $past(touch_way_i)));
endmodule

// File: rtl/cache_2way_lru.sv
module cache_2way_lru
  import cache2w_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cpu_req_i,
  input  logic                     cpu_we_i,
  input  logic [ADDR_W-1:0]        cpu_addr_i,
  input  logic [DATA_W-1:0]        cpu_wdata_i,
  output logic                     cpu_done_o,
  output logic                     cpu_hit_o,
  output logic [DATA_W-1:0]        cpu_rdata_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-OFF_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  input  logic                     mem_ack_i
);
  localparam int unsigned WADDR_W = ADDR_W - OFF_W;
  localparam int unsigned TAG_W   = ADDR_W - SET_W - OFF_W;

  ctrl_state_e state_q, state_d;

  logic [WADDR_W-1:0] waddr_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               hit_q;

  logic [TAG_W-1:0]   req_tag;
  logic [SET_W-1:0]   req_set;
  logic [NUM_WAYS-1:0] way_hit, way_valid, way_wr;
  logic [DATA_W-1:0]  way_data [NUM_WAYS];
  logic [DATA_W-1:0]  fill_data;
  logic               any_hit, lru_victim, victim, touch, touch_way, fill_done;

  assign req_tag = waddr_q[WADDR_W-1 -: TAG_W];
  assign req_set = waddr_q[SET_W-1:0];
  assign any_hit = |way_hit;

  // invalid way takes priority over the recency choice
  always_comb begin
    if (!way_valid[0])      victim = 1'b0;
    else if (!way_valid[1]) victim = 1'b1;
    else                    victim = lru_victim;
  end

  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign fill_data = (state_q == ST_FILL) ? mem_rdata_i : wdata_q;
  assign touch     = fill_done || ((state_q == ST_LOOKUP) && any_hit);
  assign touch_way = (state_q == ST_FILL) ? victim : way_hit[1];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_wr[w] = (fill_done && (victim == w)) ||
                       ((state_q == ST_LOOKUP) && we_q && way_hit[w]);

    cache_way #(
      .TAG_W (TAG_W),
      .SET_W (SET_W),
      .DATA_W(DATA_W)
    ) i_way (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (req_set),
      .tag_i    (req_tag),
      .wr_en_i  (way_wr[w]),
      .wr_data_i(fill_data),
      .hit_o    (way_hit[w]),
      .valid_o  (way_valid[w]),
      .data_o   (way_data[w])
    );
  end

  cache_lru #(.SET_W(SET_W)) i_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (req_set),
    .touch_i    (touch),
    .touch_way_i(touch_way),
    .victim_o   (lru_victim)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_req_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (we_q)         state_d = ST_WRITE;
        else if (any_hit) state_d = ST_RESP;
        else              state_d = ST_FILL;
      end
      ST_FILL:   if (mem_ack_i) state_d = ST_RESP;
      ST_WRITE:  if (mem_ack_i) state_d = ST_RESP;
      ST_RESP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      waddr_q <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req_i) begin
        waddr_q <= cpu_addr_i[ADDR_W-1:OFF_W];
        we_q    <= cpu_we_i;
        wdata_q <= cpu_wdata_i;
      end
      if (state_q == ST_LOOKUP) begin
        hit_q <= any_hit;
        if (!we_q && any_hit) rdata_q <= way_hit[1] ? way_data[1] : way_data[0];
      end
      if (fill_done) rdata_q <= mem_rdata_i;
    end
  end

  assign cpu_done_o  = (state_q == ST_RESP);
  assign cpu_hit_o   = hit_q;
  assign cpu_rdata_o = rdata_q;
  assign mem_req_o   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = waddr_q;
  assign mem_wdata_o = wdata_q;

  assert_no_dual_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(way_hit[0] && way_hit[1]));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  assert_miss_returns_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o && !we_q && !cpu_hit_o) |-> ($past(mem_ack_i) && cpu_rdata_o == $past(mem_rdata_i)));

  assert_write_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o && we_q) |-> $past(mem_ack_i));

  assert_hit_no_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o && !we_q && cpu_hit_o) |-> !$past(mem_req_o));
endmodule

// File: tb/test_cache_2way_lru.sv
module test_cache_2way_lru;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_done, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [5:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int mem_rd_cnt = 0, mem_wr_cnt = 0;
  int dly = 0;
  bit finished = 0;
  logic [31:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_2way_lru i_cache_2way_lru (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_hit_o(cpu_hit), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // memory model, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (dly == MEM_LAT) begin
        dly     <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          mem_wr_cnt    <= mem_wr_cnt + 1;
        end else begin
          mem_rdata  <= mem[mem_addr];
          mem_rd_cnt <= mem_rd_cnt + 1;
        end
      end else dly <= dly + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic hit);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int i = 0; i < 50 && !cpu_done; i++) @(negedge clk);
    rd  = cpu_rdata;
    hit = cpu_hit;
    check(cpu_done === 1'b1, "R11 done", {31'b0, cpu_done}, 32'h1);
    @(negedge clk);
    check(cpu_done === 1'b0, "R11 pulse", {31'b0, cpu_done}, 32'h0);
  endtask

  task automatic read_expect(input logic [7:0] addr, input bit exp_hit, input string req);
    logic [31:0] rd;
    logic        hit;
    int          rd0;
    rd0 = mem_rd_cnt;
    access(1'b0, addr, '0, rd, hit);
    check(hit === exp_hit, req, {31'b0, hit}, {31'b0, exp_hit});
    check(rd === mem[addr[7:2]], req, rd, mem[addr[7:2]]);
    check((mem_rd_cnt - rd0) == (exp_hit ? 0 : 1), req, mem_rd_cnt - rd0, exp_hit ? 0 : 1);
  endtask

  task automatic t_reset;
    check(cpu_done === 1'b0, "R1 done low", {31'b0, cpu_done}, 0);
    check(mem_req === 1'b0, "R1 mem idle", {31'b0, mem_req}, 0);
  endtask

  task automatic t_cold_and_hit;
    read_expect(8'h30, 1'b0, "R1 R3 cold miss");
    check(mem_addr === 6'h0C, "R2 word address", {26'b0, mem_addr}, 32'h0C);
    read_expect(8'h30, 1'b1, "R4 hit");
    read_expect(8'h33, 1'b1, "R2 byte bits ignored");
  endtask

  task automatic t_pair;
    read_expect(8'hB0, 1'b0, "R5 R6 second tag fills free way");
    read_expect(8'h30, 1'b1, "R5 first tag resident");
    read_expect(8'hB0, 1'b1, "R5 R10 second tag resident");
  endtask

  task automatic t_lru;
    read_expect(8'h14, 1'b0, "R7 fill A");
    read_expect(8'h54, 1'b0, "R7 fill B");
    read_expect(8'h14, 1'b1, "R7 hit A");
    read_expect(8'h94, 1'b0, "R7 miss C evicts B");
    read_expect(8'h14, 1'b1, "R7 A kept");
    read_expect(8'h54, 1'b0, "R7 B evicted");
  endtask

  task automatic t_write;
    logic [31:0] rd;
    logic        hit;
    int          wr0;
    read_expect(8'h28, 1'b0, "R9 prime");
    wr0 = mem_wr_cnt;
    access(1'b1, 8'h28, 32'h1234_5678, rd, hit);
    check(hit === 1'b1, "R9 write hit", {31'b0, hit}, 1);
    check(mem_wr_cnt - wr0 == 1, "R8 write through", mem_wr_cnt - wr0, 1);
    check(mem[6'h0A] === 32'h1234_5678, "R8 memory updated", mem[6'h0A], 32'h1234_5678);
    read_expect(8'h28, 1'b1, "R9 R10 updated word hits");
    check(cpu_rdata === 32'h1234_5678, "R9 new data", cpu_rdata, 32'h1234_5678);
    wr0 = mem_wr_cnt;
    access(1'b1, 8'h68, 32'hDEAD_BEEF, rd, hit);
    check(hit === 1'b0, "R9 write miss", {31'b0, hit}, 0);
    check(mem_wr_cnt - wr0 == 1, "R8 write miss reaches memory", mem_wr_cnt - wr0, 1);
    read_expect(8'h68, 1'b0, "R9 no allocate on write miss");
  endtask

  task automatic t_write_mru;
    logic [31:0] rd;
    logic        hit;
    read_expect(8'h0C, 1'b0, "R9 fill F");
    read_expect(8'h4C, 1'b0, "R9 fill G");
    access(1'b1, 8'h0C, 32'hCAFE_0001, rd, hit);
    check(hit === 1'b1, "R9 write hit F", {31'b0, hit}, 1);
    read_expect(8'h8C, 1'b0, "R9 miss H evicts G");
    read_expect(8'h0C, 1'b1, "R9 F kept after write");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_hit();
    t_pair();
    t_lru();
    t_write();
    t_write_mru();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule